// File: doc/BRIEF.md
# Segment Table Address Translator

The translator turns a logical address, made of a segment selector and an offset, into a physical address. An on-chip table holds one base and one limit for each segment. A request is legal only when its offset is strictly below the selected limit. A legal request returns base plus offset. An illegal one returns an addressing-error trap, and the physical address is forced to zero so that no memory access can follow from it.

The table is loaded through a plain programming port. A write takes effect only when the privileged-mode input is high. A write attempted without privilege leaves the table untouched and raises a one-cycle violation flag. After reset every limit is zero, so every request traps until software loads the table.

Requests and responses use valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears one cycle later in a single output register. That response holds steady until the consumer takes it on an edge where `rsp_valid` and `rsp_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rsp_valid` and `priv_err` are 0, `req_ready` is 1, and every segment has limit zero, so any request traps.
- R2: A write with `cfg_we`=1 and `cfg_priv`=1 stores `cfg_base` and `cfg_limit` into the entry chosen by `cfg_idx`.
- R3: A write with `cfg_we`=1 and `cfg_priv`=0 changes no entry, and drives `priv_err` high for exactly the following cycle.
- R4: A request is legal only when offset < limit (unsigned), so an offset equal to the limit traps.
- R5: For a legal request, `rsp_paddr` = base + offset as a 17-bit sum that keeps the carry in bit 16, with `rsp_trap`=0.
- R6: For an illegal request, `rsp_trap`=1 and `rsp_paddr`=0.
- R7: A request accepted on one edge produces `rsp_valid`=1 after that same edge, so the response is visible in the following cycle.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and the response holds stable.
- R9: When a write and a request fall in the same cycle, the request is judged against the entry as it was before that write.
- R10: Each segment uses only its own entry; writing one entry leaves the translations of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_priv | input | 1 | Privileged mode; a write is accepted only when this is high |
| cfg_idx | input | 3 | Entry to write |
| cfg_base | input | 16 | Base value to write |
| cfg_limit | input | 16 | Limit value to write |
| priv_err | output | 1 | One-cycle flag after a write attempted without privilege |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_seg | input | 3 | Segment selector |
| req_off | input | 16 | Offset within the segment |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_trap | output | 1 | Addressing-error trap |
| rsp_paddr | output | 17 | Physical address (zero on a trap) |

## Verification
A table write and a translation can arrive in the same cycle. The bench provokes this by reprogramming segment 1, raising its base and widening its limit, while it presents a segment 1 request whose offset fits only the new limit. The response must be a trap, because the old limit still applies. A second request with the same offset must then return the new base plus the offset. Back-pressure is also combined with a new request that waits while the output register is still full. The waiting request must not be taken until the consumer drains the register.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned DEF_SEG_W  = 3;
  localparam int unsigned DEF_OFF_W  = 16;
  localparam int unsigned DEF_BASE_W = 16;

  function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int unsigned SEG_W  = 3,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned BASE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_priv,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [OFF_W-1:0]  wr_limit,
  output logic              viol,
  input  logic [SEG_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [OFF_W-1:0]  rd_limit
);
  localparam int unsigned N = 1 << SEG_W;

  logic [N-1:0][BASE_W-1:0] base_q;
  logic [N-1:0][OFF_W-1:0]  lim_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
      end else if (wr_en && wr_priv && (wr_idx == SEG_W'(i))) begin
        base_q[i] <= wr_base;
        lim_q[i]  <= wr_limit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) viol <= 1'b0;
    else        viol <= wr_en && !wr_priv;
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_limit = lim_q[rd_idx];

  // R3
  unpriv_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_priv) |=> ($stable(lim_q) && $stable(base_q)));
  // R3
  unpriv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_priv) |=> viol);
endmodule

// File: rtl/seg_bounds.sv
module seg_bounds #(
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned BASE_W = 16,
  parameter int unsigned PA_W   = 17
) (
  input  logic [BASE_W-1:0] base,
  input  logic [OFF_W-1:0]  limit,
  input  logic [OFF_W-1:0]  off,
  output logic              legal,
  output logic [PA_W-1:0]   paddr
);
  logic [PA_W-1:0] sum;
  always_comb begin
    legal = off < limit;
    sum   = PA_W'(base) + PA_W'(off);
    paddr = legal ? sum : '0;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEG_W  = DEF_SEG_W,
  parameter int unsigned OFF_W  = DEF_OFF_W,
  parameter int unsigned BASE_W = DEF_BASE_W,
  localparam int unsigned PA_W  = wmax(OFF_W, BASE_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_priv,
  input  logic [SEG_W-1:0]  cfg_idx,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [OFF_W-1:0]  cfg_limit,
  output logic              priv_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_trap,
  output logic [PA_W-1:0]   rsp_paddr
);
  logic [BASE_W-1:0] sel_base;
  logic [OFF_W-1:0]  sel_limit;
  logic              legal;
  logic [PA_W-1:0]   paddr_c;
  logic              accept;

  seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_priv(cfg_priv), .wr_idx(cfg_idx),
    .wr_base(cfg_base), .wr_limit(cfg_limit), .viol(priv_err),
    .rd_idx(req_seg), .rd_base(sel_base), .rd_limit(sel_limit)
  );

  seg_bounds #(.OFF_W(OFF_W), .BASE_W(BASE_W), .PA_W(PA_W)) u_bnd (
    .base(sel_base), .limit(sel_limit), .off(req_off),
    .legal(legal), .paddr(paddr_c)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_paddr <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_trap  <= !legal;
      rsp_paddr <= paddr_c;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R7
  one_cycle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_trap)));
  // R6
  trap_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap) |-> (rsp_paddr == '0));
endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0, cfg_priv = 0;
  logic [2:0] cfg_idx = 0;
  logic [15:0] cfg_base = 0, cfg_limit = 0;
  logic priv_err;
  logic req_valid = 0, req_ready;
  logic [2:0] req_seg = 0;
  logic [15:0] req_off = 0;
  logic rsp_valid, rsp_ready = 1, rsp_trap;
  logic [16:0] rsp_paddr;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  seg_xlate dut (.*);

  // {seg, off, trap, paddr}
  localparam int NV = 9;
  localparam logic [36:0] VEC [NV] = '{
    {3'd0, 16'h0282, 1'b0, 17'h01DDA},
    {3'd1, 16'h000F, 1'b0, 17'h0200F},
    {3'd1, 16'h0010, 1'b1, 17'h00000},
    {3'd2, 16'hFFFE, 1'b0, 17'h0FFFE},
    {3'd2, 16'hFFFF, 1'b1, 17'h00000},
    {3'd3, 16'h0000, 1'b1, 17'h00000},
    {3'd7, 16'h0020, 1'b0, 17'h10010},
    {3'd7, 16'h8000, 1'b1, 17'h00000},
    {3'd5, 16'h0000, 1'b1, 17'h00000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [15:0] b, input logic [15:0] l, input logic p);
    @(negedge clk);
    cfg_we = 1; cfg_priv = p; cfg_idx = i; cfg_base = b; cfg_limit = l;
    @(negedge clk);
    cfg_we = 0; cfg_priv = 0;
  endtask

  task automatic xl(input logic [2:0] s, input logic [15:0] o, output logic t, output logic [16:0] pa);
    @(negedge clk);
    req_valid = 1; req_seg = s; req_off = o;
    @(negedge clk);
    req_valid = 0;
    chk("R7 rsp_valid", 32'(rsp_valid), 32'd1);
    t = rsp_trap; pa = rsp_paddr;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    logic t;
    logic [16:0] pa;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 priv_err", 32'(priv_err), 0);
    chk("R1 req_ready", 32'(req_ready), 1);
    xl(3'd4, 16'h0000, t, pa);
    chk("R1 trap after reset", 32'(t), 1);

    // R2 programming
    wr(3'd0, 16'h1B58, 16'h0400, 1);
    chk("R3 no flag on priv write", 32'(priv_err), 0);
    wr(3'd1, 16'h2000, 16'h0010, 1);
    wr(3'd2, 16'h0000, 16'hFFFF, 1);
    wr(3'd7, 16'hFFF0, 16'h8000, 1);
    // R3 unprivileged attempt on entry 5
    wr(3'd5, 16'h1234, 16'h0100, 0);
    chk("R3 priv_err pulse", 32'(priv_err), 1);
    @(negedge clk);
    chk("R3 priv_err one cycle", 32'(priv_err), 0);

    // R2 R4 R5 R6 R10 vector walk
    for (int k = 0; k < NV; k++) begin
      xl(VEC[k][36:34], VEC[k][33:18], t, pa);
      chk("R4/R6 trap", 32'(t), 32'(VEC[k][17]));
      chk("R5 paddr", 32'(pa), 32'(VEC[k][16:0]));
    end

    // R9 write and request in the same cycle
    @(negedge clk);
    cfg_we = 1; cfg_priv = 1; cfg_idx = 3'd1; cfg_base = 16'h3000; cfg_limit = 16'h0020;
    req_valid = 1; req_seg = 3'd1; req_off = 16'h0018;
    @(negedge clk);
    cfg_we = 0; cfg_priv = 0; req_valid = 0;
    chk("R9 old entry used", 32'(rsp_trap), 1);
    xl(3'd1, 16'h0018, t, pa);
    chk("R9 new entry after", 32'(pa), 32'h3018);
    xl(3'd0, 16'h0282, t, pa);
    chk("R10 other entry intact", 32'(pa), 32'h1DDA);

    // R8 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_seg = 3'd0; req_off = 16'h0282;
    @(negedge clk);
    req_seg = 3'd1; req_off = 16'h000F;
    chk("R8 req_ready low", 32'(req_ready), 0);
    @(negedge clk);
    chk("R8 held valid", 32'(rsp_valid), 1);
    chk("R8 held paddr", 32'(rsp_paddr), 32'h1DDA);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R8 queued req taken", 32'(rsp_paddr), 32'h300F);
    @(negedge clk);
    chk("R8 drained", 32'(rsp_valid), 0);

    summary();
  end
endmodule